// File: doc/BRIEF.md
# Interrupt Source Distribution Unit

This block is the per-source slice of a multiprocessor interrupt controller. It holds two registers for one interrupt source: a vector/priority word and a destination word. It turns the raw interrupt line into a pending state, either level-following or edge-latched, and combines that state with the mask to get the source's effective active state. Each time that state changes, it tells the affected CPU ports. A rise sends a one-cycle raise strobe. A fall sends a one-cycle lower strobe. Both strobes carry the source's index and its current priority, so a per-CPU arbiter downstream can track the source.

Delivery has two policies. In directed mode, every selected CPU gets the request. In distributed mode, exactly one selected CPU gets it, and the choice rotates, starting just after the CPU served last and wrapping at the number of CPUs present. A parameter selects the source kind. An external source has software-selectable sense and polarity. An edge-only source models a timer or inter-processor source: it has no sense or polarity bits and always latches edges.

Top module: `irq_src_distrib`

## Requirements
- R1: With the sense bit (bit 22 of the vector/priority word, 1 = level) set, the pending state follows the asserted level of the line. A raise strobe appears two clock edges after the line asserts, and a lower strobe appears two clock edges after it deasserts.
- R2: With the sense bit clear, an asserting transition of the line sets pending. Pending stays set after the line returns, until the acknowledge input clears it. Acknowledge has no effect on a level source.
- R3: Polarity bit 23 of the vector/priority word selects the asserted level of the line: 1 = high, 0 = low. The reset value is 1.
- R4: While mask bit 31 of the vector/priority word is 1 and the non-maskable flag (bit 8 of the destination word) is 0, the source is inactive. A pending request is delivered once the mask clears or the flag is set, and it is withdrawn when the mask takes effect again.
- R5: Register selector 0 is the vector/priority word: vector [15:0], priority [19:16], sense 22, polarity 23, mode 29, activity 30, mask 31. Selector 1 is the destination word: per-CPU bits [3:0] and the non-maskable flag at bit 8. The read data is registered. After reset the words read 0x80800000 and 0. The activity bit reads the effective active state and ignores writes, while the other fields take the written values.
- R6: A CPU whose destination bit is 0, or whose index is not below the CPU count input, never receives a strobe. A source that becomes active with no such CPU left produces no raise and, later, no lower.
- R7: With mode bit 29 clear, a rising active state raises every eligible CPU at once. The matching fall lowers exactly the set that was raised.
- R8: With mode bit 29 set, the raise goes to one CPU: the first eligible CPU above the last one served, or, if there is none above it, the lowest eligible CPU (wrapping at the CPU count). That CPU becomes the last one served. The last one served is CPU 0 after reset.
- R9: When the only eligible CPU is the last one served, the request goes to that CPU.
- R10: Raise and lower strobes last one cycle and occur only on a change of the active state. Holding the line, acknowledging a level source, or rewriting the registers without changing the active state gives no further strobe. The source index and priority outputs carry the source number parameter and the priority field at the time of the strobe.
- R11: An edge-only source reads its sense and polarity bits as 0, ignores writes to them, and latches a rising edge of the line into pending until acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 1 | Raw interrupt line |
| ack | input | 1 | Acknowledge; clears an edge-latched pending state |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select for writes: 0 vector/priority, 1 destination |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Register select for the registered read port |
| cpu_count | input | 3 | Number of CPUs present; CPUs at or above it are ineligible |
| rd_data | output | 32 | Registered read data |
| raise_o | output | 4 | Per-CPU one-cycle raise strobes |
| lower_o | output | 4 | Per-CPU one-cycle lower strobes |
| stb_src_o | output | 8 | Source index accompanying a strobe |
| stb_pri_o | output | 4 | Priority accompanying a strobe |

## Verification
The hardest situations to reach are the rotation corners of distributed mode. These are the wrap past the highest eligible CPU, the wrap forced early by a reduced CPU count, and the case where the last-served CPU is the only candidate. The stimulus gets there by issuing a series of short line pulses under one destination word, so that the last-served pointer moves 0, 1, 3, 0. It then lowers the CPU count to three, so that CPU 3 drops out while it is still selected, and ends on a destination holding only the CPU just served. A second instance built as an edge-only source covers the fixed-sense behaviour.

// File: rtl/srcdist_pkg.sv
package srcdist_pkg;
  localparam int REG_W      = 32;
  localparam int PRI_LSB    = 16;
  localparam int SENSE_BIT  = 22;
  localparam int POL_BIT    = 23;
  localparam int MODE_BIT   = 29;
  localparam int ACT_BIT    = 30;
  localparam int MASK_BIT   = 31;
  localparam int NOMASK_BIT = 8;

  typedef enum logic {KIND_EXTERNAL = 1'b0, KIND_EDGE_ONLY = 1'b1} src_kind_e;
  typedef enum logic {SEL_VECPRI = 1'b0, SEL_DEST = 1'b1} reg_sel_e;
endpackage

// File: rtl/srcdist_regs.sv
module srcdist_regs
  import srcdist_pkg::*;
#(
  parameter int        NUM_CPU = 4,
  parameter int        PRI_W   = 4,
  parameter int        VEC_W   = 16,
  parameter src_kind_e KIND    = KIND_EXTERNAL
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_sel,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               rd_sel,
  input  logic               act,
  output logic               mask_q,
  output logic               nomask_q,
  output logic               mode_q,
  output logic               level,
  output logic               pol_hi,
  output logic [PRI_W-1:0]   pri_q,
  output logic [VEC_W-1:0]   vec_q,
  output logic [NUM_CPU-1:0] dest_q,
  output logic [REG_W-1:0]   rd_data
);
  logic wr_vp, wr_dst;
  logic rb_sense, rb_pol;
  logic [REG_W-1:0] vp_word, dst_word;
  logic wr_unused;

  assign wr_vp     = wr_en && (wr_sel == SEL_VECPRI);
  assign wr_dst    = wr_en && (wr_sel == SEL_DEST);
  assign wr_unused = &{1'b0, wr_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= 1'b1;
      mode_q   <= 1'b0;
      pri_q    <= '0;
      vec_q    <= '0;
      nomask_q <= 1'b0;
      dest_q   <= '0;
    end else begin
      if (wr_vp) begin
        mask_q <= wr_data[MASK_BIT];
        mode_q <= wr_data[MODE_BIT];
        pri_q  <= wr_data[PRI_LSB +: PRI_W];
        vec_q  <= wr_data[VEC_W-1:0];
      end
      if (wr_dst) begin
        nomask_q <= wr_data[NOMASK_BIT];
        dest_q   <= wr_data[NUM_CPU-1:0];
      end
    end
  end

  generate
    if (KIND == KIND_EXTERNAL) begin : g_ext
      logic sense_q, pol_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          sense_q <= 1'b0;
          pol_q   <= 1'b1;
        end else if (wr_vp) begin
          sense_q <= wr_data[SENSE_BIT];
          pol_q   <= wr_data[POL_BIT];
        end
      end
      assign level    = sense_q;
      assign pol_hi   = pol_q;
      assign rb_sense = sense_q;
      assign rb_pol   = pol_q;
    end else begin : g_edge_only
      assign level    = 1'b0;
      assign pol_hi   = 1'b1;
      assign rb_sense = 1'b0;
      assign rb_pol   = 1'b0;
    end
  endgenerate

  always_comb begin
    vp_word                      = '0;
    vp_word[VEC_W-1:0]           = vec_q;
    vp_word[PRI_LSB +: PRI_W]    = pri_q;
    vp_word[SENSE_BIT]           = rb_sense;
    vp_word[POL_BIT]             = rb_pol;
    vp_word[MODE_BIT]            = mode_q;
    vp_word[ACT_BIT]             = act;
    vp_word[MASK_BIT]            = mask_q;
    dst_word                     = '0;
    dst_word[NUM_CPU-1:0]        = dest_q;
    dst_word[NOMASK_BIT]         = nomask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= (rd_sel == SEL_DEST) ? dst_word : vp_word;
  end
endmodule

// File: rtl/srcdist_pend.sv
module srcdist_pend (
  input  logic clk,
  input  logic rst,
  input  logic irq_in,
  input  logic pol_hi,
  input  logic level,
  input  logic ack,
  input  logic blocked,
  output logic act_q,
  output logic act_rise,
  output logic act_fall
);
  logic asserted, asserted_q, edge_seen, pending_q, eff_active;

  assign asserted  = pol_hi ? irq_in : ~irq_in;
  assign edge_seen = asserted & ~asserted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      asserted_q <= 1'b0;
      pending_q  <= 1'b0;
      act_q      <= 1'b0;
    end else begin
      asserted_q <= asserted;
      if (level)          pending_q <= asserted;
      else if (edge_seen) pending_q <= 1'b1;
      else if (ack)       pending_q <= 1'b0;
      act_q <= eff_active;
    end
  end

  assign eff_active = pending_q & ~blocked;
  assign act_rise   = eff_active & ~act_q;
  assign act_fall   = ~eff_active & act_q;
endmodule

// File: rtl/srcdist_route.sv
module srcdist_route #(
  parameter int NUM_CPU = 4,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CPU-1:0] dest,
  input  logic [CNT_W-1:0]   cpu_count,
  input  logic               dist_mode,
  input  logic               take,
  output logic [NUM_CPU-1:0] targets,
  output logic [NUM_CPU-1:0] dest_ok
);
  localparam int LAST_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

  logic [LAST_W-1:0] last_q, hi_idx, lo_idx, pick;
  logic              hi_hit, lo_hit, only_last;
  logic [NUM_CPU-1:0] last_onehot;

  always_comb begin
    hi_hit = 1'b0;
    lo_hit = 1'b0;
    hi_idx = '0;
    lo_idx = '0;
    for (int i = 0; i < NUM_CPU; i++) begin
      dest_ok[i] = dest[i] && (CNT_W'(i) < cpu_count);
    end
    for (int i = 0; i < NUM_CPU; i++) begin
      if (dest_ok[i]) begin
        if (LAST_W'(i) > last_q) begin
          if (!hi_hit) begin
            hi_hit = 1'b1;
            hi_idx = LAST_W'(i);
          end
        end else if (!lo_hit) begin
          lo_hit = 1'b1;
          lo_idx = LAST_W'(i);
        end
      end
    end
  end

  assign pick        = hi_hit ? hi_idx : lo_idx;
  assign last_onehot = NUM_CPU'(1) << last_q;
  assign only_last   = (dest_ok == last_onehot);

  always_comb begin
    if (dest_ok == '0)   targets = '0;
    else if (only_last)  targets = last_onehot;
    else if (!dist_mode) targets = dest_ok;
    else                 targets = NUM_CPU'(1) << pick;
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else if (take && dist_mode && (dest_ok != '0)) last_q <= pick;
  end
endmodule

// File: rtl/irq_src_distrib.sv
module irq_src_distrib
  import srcdist_pkg::*;
#(
  parameter int        NUM_CPU = 4,
  parameter int        PRI_W   = 4,
  parameter int        VEC_W   = 16,
  parameter int        SRC_W   = 8,
  parameter int        SRC_ID  = 5,
  parameter src_kind_e KIND    = KIND_EXTERNAL
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         irq_in,
  input  logic                         ack,
  input  logic                         wr_en,
  input  logic                         wr_sel,
  input  logic [31:0]                  wr_data,
  input  logic                         rd_sel,
  input  logic [$clog2(NUM_CPU+1)-1:0] cpu_count,
  output logic [31:0]                  rd_data,
  output logic [NUM_CPU-1:0]           raise_o,
  output logic [NUM_CPU-1:0]           lower_o,
  output logic [SRC_W-1:0]             stb_src_o,
  output logic [PRI_W-1:0]             stb_pri_o
);
  localparam int CNT_W = $clog2(NUM_CPU + 1);

  logic               mask_q, nomask_q, dist_mode, level, pol_hi, blocked;
  logic [PRI_W-1:0]   pri_q;
  logic [VEC_W-1:0]   vec_q;
  logic [NUM_CPU-1:0] dest_q, targets, dest_ok, delivered_q;
  logic               act_q, act_rise, act_fall;
  logic               vec_unused;

  assign blocked    = mask_q & ~nomask_q;
  assign vec_unused = ^{1'b0, vec_q};

  srcdist_regs #(.NUM_CPU(NUM_CPU), .PRI_W(PRI_W), .VEC_W(VEC_W), .KIND(KIND)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .act(act_q), .mask_q(mask_q), .nomask_q(nomask_q),
    .mode_q(dist_mode), .level(level), .pol_hi(pol_hi), .pri_q(pri_q),
    .vec_q(vec_q), .dest_q(dest_q), .rd_data(rd_data)
  );

  srcdist_pend u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .pol_hi(pol_hi), .level(level),
    .ack(ack), .blocked(blocked), .act_q(act_q), .act_rise(act_rise),
    .act_fall(act_fall)
  );

  srcdist_route #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W)) u_route (
    .clk(clk), .rst(rst), .dest(dest_q), .cpu_count(cpu_count),
    .dist_mode(dist_mode), .take(act_rise), .targets(targets), .dest_ok(dest_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      raise_o     <= '0;
      lower_o     <= '0;
      delivered_q <= '0;
      stb_src_o   <= '0;
      stb_pri_o   <= '0;
    end else begin
      raise_o <= '0;
      lower_o <= '0;
      if (act_rise) begin
        raise_o     <= targets;
        delivered_q <= targets;
        stb_src_o   <= SRC_W'(SRC_ID);
        stb_pri_o   <= pri_q;
      end else if (act_fall) begin
        lower_o     <= delivered_q;
        delivered_q <= '0;
        stb_src_o   <= SRC_W'(SRC_ID);
        stb_pri_o   <= pri_q;
      end
    end
  end
endmodule

// File: rtl/irq_src_distrib_chk.sv
module irq_src_distrib_chk #(
  parameter int NUM_CPU = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_CPU-1:0] raise_o,
  input logic [NUM_CPU-1:0] lower_o,
  input logic [NUM_CPU-1:0] dest_ok,
  input logic               act_q,
  input logic               blocked,
  input logic               dist_mode
);
  assert_raise_on_rise_R10: assert property (@(posedge clk) disable iff (rst)
    (raise_o != '0) |-> (act_q && !$past(act_q)));

  assert_lower_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
    (lower_o != '0) |-> (!act_q && $past(act_q)));

  assert_no_repeat_raise_R10: assert property (@(posedge clk) disable iff (rst)
    (raise_o != '0) |=> (raise_o == '0));

  assert_masked_goes_idle_R4: assert property (@(posedge clk) disable iff (rst)
    blocked |=> !act_q);

  assert_single_target_R8: assert property (@(posedge clk) disable iff (rst)
    $past(dist_mode) |-> $onehot0(raise_o));

  assert_only_eligible_R6: assert property (@(posedge clk) disable iff (rst)
    (raise_o & ~$past(dest_ok)) == '0);
endmodule

bind irq_src_distrib irq_src_distrib_chk #(.NUM_CPU(NUM_CPU)) u_chk (
  .clk(clk), .rst(rst), .raise_o(raise_o), .lower_o(lower_o),
  .dest_ok(dest_ok), .act_q(act_q), .blocked(blocked), .dist_mode(dist_mode)
);

// File: tb/tb_irq_src_distrib.sv
module tb_irq_src_distrib;
  import srcdist_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0, irq_b = 1'b0, ack = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [2:0]  cnt = 3'd4;
  logic [31:0] rd, rd_b;
  logic [3:0]  raise, lower, raise_b, lower_b;
  logic [7:0]  ssrc, ssrc_b;
  logic [3:0]  spri, spri_b;
  int n_vec = 0, n_bad = 0;

  always #4 clk = ~clk;

  irq_src_distrib #(.SRC_ID(5)) dut (
    .clk(clk), .rst(rst), .irq_in(irq), .ack(ack), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .cpu_count(cnt), .rd_data(rd),
    .raise_o(raise), .lower_o(lower), .stb_src_o(ssrc), .stb_pri_o(spri)
  );

  irq_src_distrib #(.SRC_ID(9), .KIND(KIND_EDGE_ONLY)) dut_b (
    .clk(clk), .rst(rst), .irq_in(irq_b), .ack(ack), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .cpu_count(cnt), .rd_data(rd_b),
    .raise_o(raise_b), .lower_o(lower_b), .stb_src_o(ssrc_b), .stb_pri_o(spri_b)
  );

  function automatic logic [31:0] vpw(bit m, bit md, bit p, bit s, logic [3:0] pr, logic [15:0] v);
    return {m, 1'b0, md, 5'b0, p, s, 2'b0, pr, v};
  endfunction

  function automatic logic [31:0] dstw(bit nm, logic [3:0] d);
    return {23'b0, nm, 4'b0, d};
  endfunction

  function automatic logic [46:0] t(bit w, bit sl, logic [31:0] d, bit i, bit a,
                                    logic [2:0] c, logic [3:0] r, logic [3:0] l);
    return {w, sl, d, i, a, c, r, l};
  endfunction

  localparam int NV = 60;
  localparam logic [46:0] TAB [NV] = '{
    t(1,0,vpw(0,0,1,1,7,16'h0123),0,0,4,0,0),
    t(1,1,dstw(0,4'b0101),0,0,4,0,0),
    t(0,0,0,1,0,4,0,0),
    t(0,0,0,1,0,4,4'b0101,0),
    t(0,0,0,1,0,4,0,0),
    t(0,0,0,0,0,4,0,0),
    t(0,0,0,0,0,4,0,4'b0101),
    t(0,0,0,0,1,4,0,0),
    t(1,0,vpw(0,0,1,0,3,16'h0055),0,0,4,0,0),
    t(0,0,0,1,0,4,0,0),
    t(0,0,0,0,0,4,4'b0101,0),
    t(0,0,0,0,0,4,0,0),
    t(0,0,0,0,1,4,0,0),
    t(0,0,0,0,0,4,0,4'b0101),
    t(1,0,vpw(0,0,0,1,2,16'h0066),0,0,4,0,0),
    t(0,0,0,1,0,4,0,0),
    t(0,0,0,0,0,4,0,0),
    t(0,0,0,0,0,4,4'b0101,0),
    t(0,0,0,1,0,4,0,0),
    t(0,0,0,1,0,4,0,4'b0101),
    t(1,0,vpw(1,0,1,1,9,16'h00AA),1,0,4,0,0),
    t(0,0,0,1,0,4,0,0),
    t(0,0,0,1,0,4,0,0),
    t(1,1,dstw(1,4'b0101),1,0,4,0,0),
    t(0,0,0,1,0,4,4'b0101,0),
    t(1,1,dstw(0,4'b0101),1,0,4,0,0),
    t(0,0,0,1,0,4,0,4'b0101),
    t(1,0,vpw(0,0,1,1,9,16'h00AA),1,0,4,0,0),
    t(0,0,0,1,0,4,4'b0101,0),
    t(0,0,0,0,0,4,0,0),
    t(0,0,0,0,0,4,0,4'b0101),
    t(1,1,dstw(0,4'b0000),1,0,4,0,0),
    t(0,0,0,1,0,4,0,0),
    t(0,0,0,0,0,4,0,0),
    t(0,0,0,0,0,4,0,0),
    t(1,1,dstw(0,4'b1100),1,0,2,0,0),
    t(0,0,0,1,0,2,0,0),
    t(0,0,0,0,0,2,0,0),
    t(0,0,0,0,0,4,0,0),
    t(1,0,vpw(0,1,1,1,4,16'h0077),0,0,4,0,0),
    t(1,1,dstw(0,4'b1011),0,0,4,0,0),
    t(0,0,0,1,0,4,0,0),
    t(0,0,0,0,0,4,4'b0010,0),
    t(0,0,0,0,0,4,0,4'b0010),
    t(0,0,0,1,0,4,0,0),
    t(0,0,0,0,0,4,4'b1000,0),
    t(0,0,0,0,0,4,0,4'b1000),
    t(0,0,0,1,0,4,0,0),
    t(0,0,0,0,0,4,4'b0001,0),
    t(0,0,0,0,0,4,0,4'b0001),
    t(0,0,0,1,0,3,0,0),
    t(0,0,0,0,0,3,4'b0010,0),
    t(0,0,0,0,0,3,0,4'b0010),
    t(0,0,0,1,0,3,0,0),
    t(0,0,0,0,0,3,4'b0001,0),
    t(0,0,0,0,0,3,0,4'b0001),
    t(1,1,dstw(0,4'b0001),0,0,4,0,0),
    t(0,0,0,1,0,4,0,0),
    t(0,0,0,0,0,4,4'b0001,0),
    t(0,0,0,0,0,4,0,4'b0001)
  };

  function automatic string req_of(int s);
    if (s < 8)  return "R1 R7";
    if (s < 14) return "R2";
    if (s < 20) return "R3";
    if (s < 31) return "R4";
    if (s < 39) return "R6";
    if (s < 56) return "R8";
    return "R9";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input bit sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog all actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc();
    chk(raise == 0 && lower == 0, "R5 reset strobes", {raise, lower}, 0);
    chk(rd == 32'h8080_0000, "R5 reset readback", rd, 32'h8080_0000);
    chk(rd_b == 32'h8000_0000, "R11 reset readback", rd_b, 32'h8000_0000);

    for (int s = 0; s < NV; s++) begin
      wr_en   = TAB[s][46];
      wr_sel  = TAB[s][45];
      wr_data = TAB[s][44:13];
      irq     = TAB[s][12];
      ack     = TAB[s][11];
      cnt     = TAB[s][10:8];
      cyc();
      chk(raise == TAB[s][7:4] && lower == TAB[s][3:0], req_of(s),
          {24'b0, raise, lower}, {24'b0, TAB[s][7:0]});
    end
    wr_en = 1'b0; ack = 1'b0; cnt = 3'd4;

    // R10 / R7: payload, no duplicate strobes, level ack ignored (R2)
    wr(0, vpw(0,0,1,1,4'hC,16'h1111));
    wr(1, dstw(0,4'b0010));
    irq = 1'b1;
    cyc(); cyc();
    chk(raise == 4'b0010, "R7 directed raise", raise, 4'b0010);
    chk(ssrc == 8'd5 && spri == 4'hC, "R10 strobe payload", {ssrc, spri}, {8'd5, 4'hC});
    cyc();
    chk(raise == 0 && lower == 0, "R10 held line no strobe", {raise, lower}, 0);
    ack = 1'b1; cyc();
    chk(lower == 0, "R2 level ack ignored", lower, 0);
    ack = 1'b0; cyc();
    chk(lower == 0, "R2 level ack ignored", lower, 0);
    rd_sel = 1'b0; cyc();
    chk(rd[30] == 1'b1, "R5 activity set", rd, 32'h4000_0000);
    wr(0, vpw(0,0,1,1,4'hC,16'h2222));
    chk(raise == 0 && lower == 0, "R10 rewrite no strobe", {raise, lower}, 0);
    cyc();
    chk(rd[30] == 1'b1 && rd[15:0] == 16'h2222, "R5 activity write ignored", rd, 32'h4000_2222);
    irq = 1'b0;
    cyc(); cyc();
    chk(lower == 4'b0010, "R7 lower same set", lower, 4'b0010);
    cyc();
    wr(0, vpw(0,0,1,1,4'hC,16'h2222) | 32'h4000_0000);
    cyc();
    chk(rd[30] == 1'b0, "R5 activity write ignored", rd, 0);
    rd_sel = 1'b1; cyc();
    chk(rd == 32'h0000_0002, "R5 destination readback", rd, 32'h2);

    // R11: edge-only source
    rd_sel = 1'b0;
    wr(0, vpw(0,0,1,1,4'h6,16'h0042));
    cyc();
    chk(rd_b[23:22] == 2'b00 && rd_b[19:16] == 4'h6, "R11 sense/polarity fixed", rd_b, 32'h0006_0042);
    irq_b = 1'b1;
    cyc(); cyc();
    chk(raise_b == 4'b0010 && ssrc_b == 8'd9, "R11 edge raise", {ssrc_b, raise_b}, {8'd9, 4'b0010});
    cyc(); cyc();
    chk(lower_b == 0, "R11 held pending", lower_b, 0);
    irq_b = 1'b0;
    cyc(); cyc();
    chk(lower_b == 0, "R11 latched after release", lower_b, 0);
    ack = 1'b1; cyc();
    ack = 1'b0; cyc();
    chk(lower_b == 4'b0010, "R11 ack clears", lower_b, 4'b0010);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule